// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control core of a gum dispenser whose single slot accepts five-cent and ten-cent coins, one per clock cycle. Each coin strobe adds to a credit held in a four-level state machine (0, 5, 10 and 15 cents). Once the credit reaches 15 cents the release output is raised and the machine parks there. Extra coins are kept and no change is ever returned.

A release timer inside the block starts counting when the registered release output rises. After a parameterised number of cycles it emits a one-cycle time-out pulse. That pulse, ORed with the external reset, empties the credit at the next clock edge, so one purchase leads to exactly one release window. Two release outputs are provided. One is a state-only (Moore) output decoded from the credit register. The other is an early (Mealy) output that also reacts to the coin arriving in the current cycle.

Top module: `vend_ctrl`

## Requirements
- R1: `ext_rst` is sampled at the rising clock edge. In the cycle after a cycle with `ext_rst` high, the credit is 0 cents, `open_moore` and `release_timeout` are low, and any coin strobed during the reset cycle has been discarded.
- R2: In a cycle without reset or time-out, a `nickel` strobe adds 5 cents and a `dime` strobe adds 10 cents to the credit at the next edge. With neither strobe the credit holds.
- R3: Credit saturates at 15 cents. From 10 cents either coin goes to 15, and at 15 cents coins have no effect until a reset or time-out.
- R4: When `nickel` and `dime` are high in the same cycle, only the dime is counted.
- R5: `open_moore` is high exactly in the cycles where the registered credit equals 15 cents.
- R6: `open_mealy` is high when `ext_rst` is low and either the credit is 15 cents or the credit plus the coin strobed in the same cycle reaches 15 cents.
- R7: `release_timeout` is a single-cycle pulse. Counting the first cycle with `open_moore` high as cycle 1, the pulse appears in cycle `DELAY_CYCLES`+1, and only while `open_moore` is high.
- R8: At the edge ending a `release_timeout` cycle the credit returns to 0 cents, and any coin in that cycle is discarded. `open_moore` is therefore low in the next cycle, so the release window lasts exactly `DELAY_CYCLES`+1 cycles.
- R9: An `ext_rst` during a release window stops the timer. The next purchase then gets a full window of `DELAY_CYCLES`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| ext_rst | input | 1 | Synchronous external reset, active high |
| nickel | input | 1 | Five-cent coin strobe, one cycle per coin |
| dime | input | 1 | Ten-cent coin strobe, one cycle per coin |
| open_moore | output | 1 | Release output decoded from the credit register |
| open_mealy | output | 1 | Early release output including the current coin |
| release_timeout | output | 1 | One-cycle pulse that ends the release window |

## Verification
The hardest situations to reach are the ones at the edges of the release window. These are a coin arriving in the very cycle of the time-out pulse, and an external reset that cuts a window short while the timer is partway through its count. The directed part of the stimulus reaches them on purpose. It feeds coins on every cycle of a window, so that one lands in the pulse cycle. It also resets a few cycles into a window and then makes a second purchase whose window length is counted. A long run of seeded random coins and rare resets then compares all three outputs every cycle against a cycle model kept in the bench.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_e;

    typedef enum logic [1:0] {
        TM_IDLE  = 2'b00,
        TM_RUN   = 2'b01,
        TM_SPENT = 2'b10
    } tmr_phase_e;

    // Credit after one accepted coin; dime wins over nickel.
    function automatic credit_e credit_add(input credit_e cur, input logic nk, input logic dm);
        credit_e nxt;
        nxt = cur;
        unique case (cur)
            CR_0:  nxt = dm ? CR_10 : (nk ? CR_5 : CR_0);
            CR_5:  nxt = dm ? CR_15 : (nk ? CR_10 : CR_5);
            CR_10: nxt = (dm || nk) ? CR_15 : CR_10;
            CR_15: nxt = CR_15;
            default: nxt = CR_0;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    clear,
    input  logic    nickel,
    input  logic    dime,
    output credit_e credit
);

    typedef struct packed {
        credit_e credit;
    } credit_st_t;

    credit_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.credit = CR_0;
        end else begin
            st_d.credit = credit_add(st_q.credit, nickel, dime);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign credit = st_q.credit;

    p_hold15_r3: assert property (@(posedge clk) disable iff (clear)
        (st_q.credit == CR_15) |=> (st_q.credit == CR_15));

    p_dime_wins_r4: assert property (@(posedge clk) disable iff (clear)
        (st_q.credit == CR_0 && dime) |=> (st_q.credit == CR_10));

    p_nickel_step_r2: assert property (@(posedge clk) disable iff (clear)
        (st_q.credit == CR_0 && nickel && !dime) |=> (st_q.credit == CR_5));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (clear)
        (!nickel && !dime) |=> $stable(st_q.credit));

endmodule

// File: rtl/vend_release_timer.sv
module vend_release_timer
    import vend_pkg::*;
#(
    parameter int DELAY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    output logic timeout
);

    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

    typedef struct packed {
        tmr_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             tmo;
    } tmr_st_t;

    tmr_st_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.tmo = 1'b0;
        if (rst) begin
            t_d.phase = TM_IDLE;
            t_d.cnt   = '0;
        end else begin
            unique case (t_q.phase)
                TM_IDLE: begin
                    if (open_i) begin
                        t_d.phase = TM_RUN;
                        t_d.cnt   = CNT_W'(1);
                    end
                end
                TM_RUN: begin
                    if (!open_i) begin
                        t_d.phase = TM_IDLE;
                        t_d.cnt   = '0;
                    end else if (t_q.cnt == LAST) begin
                        t_d.phase = TM_SPENT;
                        t_d.cnt   = '0;
                        t_d.tmo   = 1'b1;
                    end else begin
                        t_d.cnt = t_q.cnt + CNT_W'(1);
                    end
                end
                TM_SPENT: begin
                    if (!open_i) t_d.phase = TM_IDLE;
                end
                default: begin
                    t_d.phase = TM_IDLE;
                    t_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign timeout = t_q.tmo;

    p_tmo_single_r7: assert property (@(posedge clk) disable iff (rst)
        t_q.tmo |=> !t_q.tmo);

    p_tmo_while_open_r7: assert property (@(posedge clk) disable iff (rst)
        t_q.tmo |-> open_i);

    p_rearm_low_r9: assert property (@(posedge clk) disable iff (rst)
        (t_q.phase == TM_SPENT && open_i) |=> (t_q.phase == TM_SPENT));

endmodule

// File: rtl/vend_open_decode.sv
module vend_open_decode
    import vend_pkg::*;
(
    input  credit_e credit,
    input  logic    nickel,
    input  logic    dime,
    input  logic    ext_rst,
    output logic    open_moore,
    output logic    open_mealy
);

    logic q1, q0;

    always_comb begin
        q1         = credit[1];
        q0         = credit[0];
        open_moore = q1 & q0;
        open_mealy = ~ext_rst & ((q1 & q0) | (dime & q0) | (dime & q1) | (nickel & q1));
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
    parameter int DELAY_CYCLES = 16
) (
    input  logic clk,
    input  logic ext_rst,
    input  logic nickel,
    input  logic dime,
    output logic open_moore,
    output logic open_mealy,
    output logic release_timeout
);

    import vend_pkg::*;

    credit_e credit;
    logic    tmo;
    logic    eff_rst;

    assign eff_rst = ext_rst | tmo;

    vend_credit_fsm u_credit (
        .clk    (clk),
        .clear  (eff_rst),
        .nickel (nickel),
        .dime   (dime),
        .credit (credit)
    );

    vend_open_decode u_decode (
        .credit     (credit),
        .nickel     (nickel),
        .dime       (dime),
        .ext_rst    (ext_rst),
        .open_moore (open_moore),
        .open_mealy (open_mealy)
    );

    vend_release_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (ext_rst),
        .open_i  (open_moore),
        .timeout (tmo)
    );

    assign release_timeout = tmo;

    p_tmo_clears_r8: assert property (@(posedge clk) disable iff (ext_rst)
        release_timeout |=> !open_moore);

    p_moore_in_mealy_r6: assert property (@(posedge clk) disable iff (ext_rst)
        open_moore |-> open_mealy);

endmodule

// File: tb/vend_ctrl_bench.sv
`timescale 1ns/1ps
module vend_ctrl_bench;

    localparam int DELAY = 6;

    logic clk = 1'b0;
    logic ext_rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic open_moore, open_mealy, release_timeout;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string ptag = "INIT";

    // bench model
    int m_credit = 0;
    int m_phase = 0;
    int m_cnt = 0;
    bit m_tmo = 0;
    bit obs_moore, obs_mealy, obs_tmo;

    always #5 clk = ~clk;

    vend_ctrl #(.DELAY_CYCLES(DELAY)) u_vend_ctrl (
        .clk             (clk),
        .ext_rst         (ext_rst),
        .nickel          (nickel),
        .dime            (dime),
        .open_moore      (open_moore),
        .open_mealy      (open_mealy),
        .release_timeout (release_timeout)
    );

    task automatic chk(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (phase %s) t=%0t act=%0b exp=%0b", tag, ptag, $time, act, exp);
        end
    endtask

    function automatic int coin_val(input bit n, input bit d);
        return d ? 10 : (n ? 5 : 0);
    endfunction

    function automatic bit exp_mealy_f(input int cr, input bit n, input bit d, input bit r);
        return !r && ((cr + coin_val(n, d)) >= 15);
    endfunction

    task automatic step(input bit n, input bit d, input bit r);
        bit em;
        int np, nc;
        bit nt;
        @(negedge clk);
        nickel = n; dime = d; ext_rst = r;
        #1;
        obs_moore = open_moore; obs_mealy = open_mealy; obs_tmo = release_timeout;
        em = (m_credit == 15);
        chk(obs_moore, em, "R5");
        chk(obs_mealy, exp_mealy_f(m_credit, n, d, r), "R6");
        chk(obs_tmo, m_tmo, "R7");
        np = m_phase; nc = m_cnt; nt = 0;
        if (r) begin
            np = 0; nc = 0;
        end else if (m_phase == 0) begin
            if (em) begin np = 1; nc = 1; end
        end else if (m_phase == 1) begin
            if (!em) begin np = 0; nc = 0; end
            else if (m_cnt == DELAY - 1) begin np = 2; nc = 0; nt = 1; end
            else nc = m_cnt + 1;
        end else begin
            if (!em) np = 0;
        end
        if (r || m_tmo) m_credit = 0;
        else if (m_credit + coin_val(n, d) >= 15) m_credit = 15;
        else m_credit = m_credit + coin_val(n, d);
        m_phase = np; m_cnt = nc; m_tmo = nt;
        @(posedge clk);
    endtask

    task automatic drain();
        for (int k = 0; k < 4 * DELAY; k++) begin
            step(0, 0, 0);
            if (!obs_moore) break;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int hi;
        void'($urandom(32'd2024));

        // R1: reset state and coins ignored during reset
        ptag = "R1";
        step(0, 0, 1);
        step(0, 1, 1);
        step(0, 0, 0);
        chk(obs_moore, 0, "R1");
        chk(obs_mealy, 0, "R1");
        chk(obs_tmo, 0, "R1");
        step(0, 1, 0);
        chk(obs_mealy, 0, "R1");

        // R2: three nickels reach 15
        ptag = "R2";
        step(0, 0, 1);
        step(1, 0, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        chk(obs_moore, 0, "R2");
        step(1, 0, 0);
        chk(obs_mealy, 1, "R2");
        step(0, 0, 0);
        chk(obs_moore, 1, "R2");
        drain();

        // R4: simultaneous strobes count as a dime
        ptag = "R4";
        step(1, 1, 0);
        step(0, 0, 0);
        chk(obs_moore, 0, "R4");
        chk(obs_mealy, 0, "R4");
        step(1, 0, 0);
        chk(obs_mealy, 1, "R4");
        step(0, 0, 0);
        chk(obs_moore, 1, "R4");
        drain();

        // R6: Mealy leads Moore on the completing coin
        ptag = "R6";
        step(0, 1, 0);
        step(1, 0, 0);
        chk(obs_mealy, 1, "R6");
        chk(obs_moore, 0, "R6");
        drain();

        // R3 / R7 / R8: overpay, coins every cycle of the window
        ptag = "R3";
        step(0, 1, 0);
        step(0, 1, 0);
        hi = 0;
        for (int k = 0; k < 4 * DELAY; k++) begin
            step(1, k[0], 0);
            if (obs_moore) hi++;
            else break;
        end
        chk(hi == DELAY + 1, 1, "R7");
        chk(obs_moore, 0, "R8");
        chk(obs_mealy, 0, "R8");

        // R9: reset mid-window, next purchase gets full window
        ptag = "R9";
        step(1, 0, 0);
        step(0, 1, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        step(0, 0, 1);
        step(0, 0, 0);
        chk(obs_moore, 0, "R9");
        chk(obs_tmo, 0, "R9");
        step(0, 1, 0);
        step(1, 0, 0);
        hi = 0;
        for (int k = 0; k < 4 * DELAY; k++) begin
            step(0, 0, 0);
            if (obs_moore) hi++;
            else break;
        end
        chk(hi == DELAY + 1, 1, "R9");

        // random mix
        ptag = "RND";
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 64) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule